// File: doc/BRIEF.md
# Multi-cycle instruction timing sequencer

This block is the control sequencer of a small multi-cycle 32-bit integer core. It receives the class of the current instruction from the decoder. For every clock cycle it produces the strobes the datapath needs: register read, execute, memory access, memory write, register writeback and PC update. It also raises a fetch request for the next instruction and a one-cycle retire pulse.

Each class has a fixed budget of two or three cycles. The fetch of the next instruction sits in the final cycle of the current one, so fetch adds no cycles to any budget. A shift instruction holds its execute cycle for as long as the shifter reports busy. Any cycle that uses the memory port waits while memory is not ready, and every strobe stays steady during that wait. Fences take two cycles and write nothing.

The class code is sampled in the cycle in which a fetch completes (fetch request and memory ready both high). Execution of that instruction starts on the next cycle. The datapath commits its register and PC writes in the cycle where the retire pulse is high.

Top module: `mc_seq`

## Requirements
- R1: After reset the sequencer is in a boot state. In that state only `fetch_req` is high and `retire` stays low. It leaves the boot state at the first cycle in which `mem_ready` is high, and the first instruction starts on the next cycle.
- R2: The class codes are: 0 register-register ALU, 1 register-immediate ALU, 2 shift, 3 load, 4 store, 5 conditional branch, 6 JAL, 7 JALR, 8 fence. Codes 0, 3, 5 and 7 take 3 cycles; all other codes take 2 cycles, before any stall.
- R3: Strobes for ALU-type instructions, by cycle:
  - Register-register: cycle 0 has `rd_en`; cycle 1 has `ex_en`; cycle 2 has `wb_en`, `pc_en` and `fetch_req`.
  - Register-immediate: cycle 0 has `rd_en`; cycle 1 has `ex_en`, `wb_en`, `pc_en` and `fetch_req`.
- R4: Strobes for memory instructions, by cycle:
  - Load: cycle 0 has `rd_en`; cycle 1 has `ex_en` and `mem_en`; cycle 2 has `wb_en`, `pc_en` and `fetch_req`.
  - Store: cycle 0 has `rd_en`, `ex_en`, `mem_en` and `mem_wr`; cycle 1 has `pc_en` and `fetch_req`.
- R5: Strobes for control-transfer instructions, by cycle:
  - Branch: cycle 0 has `rd_en`; cycle 1 has `ex_en`; cycle 2 has `pc_en` and `fetch_req`.
  - JAL: cycle 0 has `ex_en`; cycle 1 has `wb_en`, `pc_en` and `fetch_req`.
  - JALR follows the register-register ALU pattern.
- R6: A fence (code 8) and every code from 9 to 15 act as a fence. A fence has no strobe in cycle 0 and only `pc_en` and `fetch_req` in cycle 1. It never raises `wb_en`, `mem_en` or `mem_wr`.
- R7: `fetch_req` is high only in an instruction's final cycle (or in boot). It is high there together with `pc_en`, and never in the same cycle as `mem_en`.
- R8: A shift has `rd_en` in cycle 0 and `ex_en` in cycle 1. While `shift_busy` is high in cycle 1, only `ex_en` is high and the instruction does not advance. In the first cycle 1 with `shift_busy` low, `wb_en`, `pc_en` and `fetch_req` join `ex_en`. Each busy cycle adds exactly one cycle.
- R9: A cycle with `mem_en` or `fetch_req` high and `mem_ready` low is stalled. In that cycle the strobes repeat unchanged on the next cycle, `retire` stays low, and each such cycle adds exactly one cycle.
- R10: `retire` is high for exactly one cycle per instruction: the final cycle in which the fetch completes. `retire` is never high in two consecutive cycles.
- R11: `mem_wr` is high only together with `mem_en`, only for stores, and never with `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_class | input | CLS_W (4) | Decoded class of the instruction being fetched; sampled when a fetch completes |
| shift_busy | input | 1 | Shifter still working on the current shift |
| mem_ready | input | 1 | The memory access or fetch of this cycle completes |
| rd_en | output | 1 | Register file read strobe |
| ex_en | output | 1 | Execute (adder/ALU) strobe |
| mem_en | output | 1 | Data memory access strobe |
| mem_wr | output | 1 | Data memory access is a write |
| wb_en | output | 1 | Register writeback strobe |
| pc_en | output | 1 | PC update strobe |
| fetch_req | output | 1 | Fetch request for the next instruction |
| retire | output | 1 | Instruction-retired pulse |

## Verification
The checker watches, on every cycle, the relations among the strobes:
- the fetch and data accesses never collide;
- a write always travels with an access and never with writeback;
- retire only comes with a completed fetch and the PC update, and never twice in a row;
- a stalled data access holds its strobes into the next cycle.

Only the bench scenarios can show the exact cycle budget and strobe order of each class code, including codes 9 to 15. They also show that shift-busy and memory-wait cycles each add exactly one cycle, and that boot waits for the first fetch. These properties depend on the class that was sampled, which is not visible at the ports.

// File: rtl/mcseq_pkg.sv
package mcseq_pkg;

   localparam int CLS_W_PKG = 4;

   typedef enum logic [CLS_W_PKG-1:0] {
      CL_ALU_RR = 4'd0,
      CL_ALU_RI = 4'd1,
      CL_SHIFT  = 4'd2,
      CL_LOAD   = 4'd3,
      CL_STORE  = 4'd4,
      CL_BRANCH = 4'd5,
      CL_JAL    = 4'd6,
      CL_JALR   = 4'd7,
      CL_FENCE  = 4'd8
   } cls_e;

   typedef struct packed {
      logic rd;
      logic ex;
      logic mem;
      logic wr;
      logic wb;
      logic pc;
      logic fetch;
   } strobe_t;

   localparam int unsigned MAX_BUDGET = 3;

   function automatic int unsigned cls_budget(cls_e c);
      case (c)
         CL_ALU_RR, CL_LOAD, CL_BRANCH, CL_JALR: return 3;
         default:                                return 2;
      endcase
   endfunction

   function automatic cls_e cls_norm(logic [CLS_W_PKG-1:0] raw);
      if (raw > CLS_W_PKG'(CL_FENCE)) return CL_FENCE;
      return cls_e'(raw);
   endfunction

endpackage

// File: rtl/mcseq_step_table.sv
module mcseq_step_table
   import mcseq_pkg::*;
#(
   parameter int STEP_W     = 2,
   parameter bit SHIFT_HOLD = 1'b1
) (
   input  cls_e              cls,
   input  logic [STEP_W-1:0] step,
   input  logic              shift_busy,
   output strobe_t           strb,
   output logic              last,
   output logic              hold
);

   localparam logic [STEP_W-1:0] S0 = STEP_W'(0);
   localparam logic [STEP_W-1:0] S1 = STEP_W'(1);
   localparam logic [STEP_W-1:0] S2 = STEP_W'(2);

   logic hold_raw;

   generate
      if (SHIFT_HOLD) begin : g_hold
         assign hold_raw = (cls == CL_SHIFT) && (step == S1) && shift_busy;
      end else begin : g_nohold
         assign hold_raw = 1'b0;
      end
   endgenerate

   assign hold = hold_raw;
   assign last = (step == STEP_W'(cls_budget(cls) - 1));

   always_comb begin
      strb = '0;
      case (cls)
         CL_ALU_RR, CL_JALR: begin
            if (step == S0) strb.rd = 1'b1;
            if (step == S1) strb.ex = 1'b1;
            if (step == S2) begin
               strb.wb    = 1'b1;
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
         CL_ALU_RI: begin
            if (step == S0) strb.rd = 1'b1;
            if (step == S1) begin
               strb.ex    = 1'b1;
               strb.wb    = 1'b1;
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
         CL_SHIFT: begin
            if (step == S0) strb.rd = 1'b1;
            if (step == S1) begin
               strb.ex    = 1'b1;
               strb.wb    = ~hold_raw;
               strb.pc    = ~hold_raw;
               strb.fetch = ~hold_raw;
            end
         end
         CL_LOAD: begin
            if (step == S0) strb.rd = 1'b1;
            if (step == S1) begin
               strb.ex  = 1'b1;
               strb.mem = 1'b1;
            end
            if (step == S2) begin
               strb.wb    = 1'b1;
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
         CL_STORE: begin
            if (step == S0) begin
               strb.rd  = 1'b1;
               strb.ex  = 1'b1;
               strb.mem = 1'b1;
               strb.wr  = 1'b1;
            end
            if (step == S1) begin
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
         CL_BRANCH: begin
            if (step == S0) strb.rd = 1'b1;
            if (step == S1) strb.ex = 1'b1;
            if (step == S2) begin
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
         CL_JAL: begin
            if (step == S0) strb.ex = 1'b1;
            if (step == S1) begin
               strb.wb    = 1'b1;
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
         default: begin
            if (step == S1) begin
               strb.pc    = 1'b1;
               strb.fetch = 1'b1;
            end
         end
      endcase
   end

endmodule

// File: rtl/mcseq_state.sv
module mcseq_state
   import mcseq_pkg::*;
#(
   parameter int STEP_W = 2,
   parameter int CLS_W  = CLS_W_PKG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              last,
   input  logic [CLS_W-1:0]  ins_class,
   output logic              booted,
   output cls_e              cls_q,
   output logic [STEP_W-1:0] step_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         booted <= 1'b0;
         cls_q  <= CL_FENCE;
         step_q <= '0;
      end else if (advance) begin
         if (!booted || last) begin
            booted <= 1'b1;
            cls_q  <= cls_norm(ins_class);
            step_q <= '0;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/mc_seq.sv
module mc_seq
   import mcseq_pkg::*;
#(
   parameter int CLS_W      = 4,
   parameter int STEP_W     = 2,
   parameter bit SHIFT_HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CLS_W-1:0] ins_class,
   input  logic             shift_busy,
   input  logic             mem_ready,
   output logic             rd_en,
   output logic             ex_en,
   output logic             mem_en,
   output logic             mem_wr,
   output logic             wb_en,
   output logic             pc_en,
   output logic             fetch_req,
   output logic             retire
);

   localparam strobe_t BOOT_STRB = '{fetch: 1'b1, default: 1'b0};

   generate
      if (CLS_W != CLS_W_PKG) begin : g_bad_cls
         $error("mc_seq: CLS_W must equal the package class width");
      end
      if ((1 << STEP_W) < MAX_BUDGET) begin : g_bad_step
         $error("mc_seq: STEP_W too narrow for the longest budget");
      end
   endgenerate

   logic              booted;
   cls_e              cls_q;
   logic [STEP_W-1:0] step_q;
   strobe_t           tbl_strb;
   strobe_t           strb;
   logic              tbl_last;
   logic              tbl_hold;
   logic              mem_wait;
   logic              advance;

   mcseq_step_table #(
      .STEP_W     (STEP_W),
      .SHIFT_HOLD (SHIFT_HOLD)
   ) u_table (
      .cls        (cls_q),
      .step       (step_q),
      .shift_busy (shift_busy),
      .strb       (tbl_strb),
      .last       (tbl_last),
      .hold       (tbl_hold)
   );

   assign strb     = booted ? tbl_strb : BOOT_STRB;
   assign mem_wait = (strb.mem | strb.fetch) & ~mem_ready;
   assign advance  = ~mem_wait & ~(booted & tbl_hold);

   mcseq_state #(
      .STEP_W (STEP_W),
      .CLS_W  (CLS_W)
   ) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (advance),
      .last      (tbl_last),
      .ins_class (ins_class),
      .booted    (booted),
      .cls_q     (cls_q),
      .step_q    (step_q)
   );

   assign rd_en     = strb.rd;
   assign ex_en     = strb.ex;
   assign mem_en    = strb.mem;
   assign mem_wr    = strb.wr;
   assign wb_en     = strb.wb;
   assign pc_en     = strb.pc;
   assign fetch_req = strb.fetch;
   assign retire    = booted & tbl_last & advance;

endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic mem_ready,
   input logic rd_en,
   input logic ex_en,
   input logic mem_en,
   input logic mem_wr,
   input logic wb_en,
   input logic pc_en,
   input logic fetch_req,
   input logic retire
);

   // R10
   retire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> !retire);

   // R10
   retire_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (fetch_req && mem_ready && pc_en));

   // R7
   fetch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !mem_en);

   // R7
   pc_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_en |-> fetch_req);

   // R11
   wr_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_en && !wb_en));

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_ready) |=>
         ($stable({rd_en, ex_en, mem_en, mem_wr, wb_en, pc_en, fetch_req}) && !retire));

   // R9
   fetch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !mem_ready) |-> !retire);

endmodule

bind mc_seq mc_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_ready (mem_ready),
   .rd_en     (rd_en),
   .ex_en     (ex_en),
   .mem_en    (mem_en),
   .mem_wr    (mem_wr),
   .wb_en     (wb_en),
   .pc_en     (pc_en),
   .fetch_req (fetch_req),
   .retire    (retire)
);

// File: tb/mc_seq_tb.sv
module mc_seq_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] ins_class;
   logic       shift_busy;
   logic       mem_ready;
   logic       rd_en, ex_en, mem_en, mem_wr, wb_en, pc_en, fetch_req, retire;

   int checks = 0;
   int fails  = 0;
   int cur    = 0;
   bit ended  = 1'b0;

   always #10 clk = ~clk;

   mc_seq u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ins_class  (ins_class),
      .shift_busy (shift_busy),
      .mem_ready  (mem_ready),
      .rd_en      (rd_en),
      .ex_en      (ex_en),
      .mem_en     (mem_en),
      .mem_wr     (mem_wr),
      .wb_en      (wb_en),
      .pc_en      (pc_en),
      .fetch_req  (fetch_req),
      .retire     (retire)
   );

   task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic int norm(int c);
      return (c > 8) ? 8 : c;
   endfunction

   function automatic int budget(int c);
      int n = norm(c);
      return (n == 0 || n == 3 || n == 5 || n == 7) ? 3 : 2;
   endfunction

   function automatic string req_of(int c);
      case (norm(c))
         0, 1:    return "R3";
         2:       return "R8";
         3, 4:    return "R4";
         5, 6, 7: return "R5";
         default: return "R6";
      endcase
   endfunction

   // strobe order {rd, ex, mem, wr, wb, pc, fetch}
   function automatic logic [6:0] exp_strb(int c, int s, bit busy);
      case (norm(c))
         0, 7: return (s == 0) ? 7'b1000000 : (s == 1) ? 7'b0100000 : 7'b0000111;
         1:    return (s == 0) ? 7'b1000000 : 7'b0100111;
         2:    return (s == 0) ? 7'b1000000 : (busy ? 7'b0100000 : 7'b0100111);
         3:    return (s == 0) ? 7'b1000000 : (s == 1) ? 7'b0110000 : 7'b0000111;
         4:    return (s == 0) ? 7'b1111000 : 7'b0000011;
         5:    return (s == 0) ? 7'b1000000 : (s == 1) ? 7'b0100000 : 7'b0000011;
         6:    return (s == 0) ? 7'b0100000 : 7'b0000111;
         default: return (s == 0) ? 7'b0000000 : 7'b0000011;
      endcase
   endfunction

   // Runs instruction `cur` to its retire; `nxt` is presented during its fetch.
   task automatic run_insn(int nxt, int busy_n, int stall_n);
      int         c = cur;
      int         step = 0;
      int         cyc = 0;
      int         busy_left = busy_n;
      int         stall_left = stall_n;
      bit         done = 1'b0;
      bit         b;
      bit         st;
      bit         exp_ret;
      logic [6:0] e;
      logic [6:0] got;
      while (!done && cyc < 40) begin
         @(negedge clk);
         b  = (norm(c) == 2) && (step == 1) && (busy_left > 0);
         e  = exp_strb(c, step, b);
         st = (e[4] | e[0]) && (stall_left > 0) && !b;
         shift_busy = b;
         mem_ready  = !st;
         ins_class  = 4'(nxt);
         #1;
         got = {rd_en, ex_en, mem_en, mem_wr, wb_en, pc_en, fetch_req};
         chk(got == e, req_of(c), $sformatf("strobes cls=%0d step=%0d", c, step), 32'(got), 32'(e));
         chk(fetch_req == (step == budget(c) - 1 && !b), "R7", "fetch only in final cycle",
             32'(fetch_req), 32'(step == budget(c) - 1 && !b));
         if (st) chk(retire == 1'b0, "R9", "no retire while memory waits", 32'(retire), 0);
         exp_ret = (step == budget(c) - 1) && !b && !st;
         chk(retire == exp_ret, "R10", $sformatf("retire cls=%0d step=%0d", c, step),
             32'(retire), 32'(exp_ret));
         if (norm(c) != 4) chk(mem_wr == 1'b0, "R11", "write only for stores", 32'(mem_wr), 0);
         cyc++;
         if (b) busy_left--;
         else if (st) stall_left--;
         else if (exp_ret) done = 1'b1;
         else step++;
      end
      chk(cyc == budget(c) + busy_n + stall_n, "R2", $sformatf("cycle count cls=%0d", c),
          32'(cyc), 32'(budget(c) + busy_n + stall_n));
      cur = nxt;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         fails++;
         $display("FAIL watchdog expired act=0 exp=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n      = 1'b0;
      ins_class  = 4'd0;
      shift_busy = 1'b0;
      mem_ready  = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      // R1 reset state
      chk({rd_en, ex_en, mem_en, mem_wr, wb_en, pc_en, fetch_req} == 7'b0000001, "R1",
          "reset strobes", 32'({rd_en, ex_en, mem_en, mem_wr, wb_en, pc_en, fetch_req}), 1);
      chk(retire == 1'b0, "R1", "reset retire", 32'(retire), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 boot waits for the first fetch
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         mem_ready = 1'b0;
         #1;
         chk({rd_en, ex_en, mem_en, wb_en, pc_en, fetch_req} == 6'b000001, "R1",
             "boot waits with fetch only", 32'({rd_en, ex_en, mem_en, wb_en, pc_en, fetch_req}), 1);
         chk(retire == 1'b0, "R1", "no retire in boot", 32'(retire), 0);
      end
      @(negedge clk);
      mem_ready = 1'b1;
      ins_class = 4'd0;
      #1;
      chk(fetch_req == 1'b1 && retire == 1'b0, "R1", "boot fetch completes",
          32'({fetch_req, retire}), 32'h2);
      cur = 0;
      // R2 R3 R4 R5 R6: every class code in turn
      for (int c = 1; c < 16; c++) run_insn(c, 0, 0);
      run_insn(2, 0, 0);
      // R8: shift busy sweep
      for (int bn = 0; bn < 5; bn++) run_insn(2, bn, 0);
      run_insn(3, 0, 0);
      // R9: memory waits on data accesses and fetches
      for (int sn = 1; sn < 4; sn++) run_insn(3, 0, sn);
      run_insn(4, 0, 0);
      for (int sn = 1; sn < 4; sn++) run_insn(4, 0, sn);
      for (int sn = 1; sn < 3; sn++) run_insn(8, 0, sn);
      run_insn(2, 0, 2);
      run_insn(0, 3, 2);
      // mixed stream
      run_insn(5, 0, 0);
      run_insn(6, 0, 1);
      run_insn(7, 0, 0);
      run_insn(1, 0, 0);
      run_insn(4, 0, 0);
      run_insn(3, 0, 0);
      run_insn(0, 0, 0);
      if (!ended) begin
         ended = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule